// File: doc/BRIEF.md
# Prefetching Block-RAM Source for Outbound DMA

This block feeds outbound data to a bus-master transfer engine from a 4 KB on-chip block RAM whose read data arrives one clock after the address. The engine shares one output bus between two phases. During the attribute phase the bus carries the transfer attributes. During the data phase it carries RAM words. The engine paces the data phase with a next-data strobe, which means "the following word must be on the bus next cycle".

A start request arms the block and returns the read pointer to the block base. In the attribute-valid cycle the block already issues the read of the first word, so that word sits in the RAM output register when the engine raises its first next-data strobe. The engine takes that word at that strobe. Each strobe then fetches the following word, so the RAM latency never stalls the engine.

After the last word of the block has been handed over, the block raises a done flag. It issues no read past the final address and ignores further strobes until the next start request.

Top module: `dma_prefetch_src`

## Requirements
- R1: After reset, `done` is 0 and `ramEn` is 0.
- R2: In every cycle where `attrValid` is 1, `busOut` equals `attrIn`.
- R3: In the first `attrValid` cycle after a start request, `ramEn` is 1 and `ramAddr` equals the block base address (0 by default).
- R4: In the cycle of the k-th accepted `nextData` strobe (k counting from 0), `busOut` holds RAM word base+k. With `attrValid` low, `busOut` shows the RAM read port.
- R5: Reads within a transfer target consecutive addresses, starting at the base and rising by one per read.
- R6: `ramEn` is high only in a cycle where `attrValid` or `nextData` is high.
- R7: `done` rises in the cycle after the 1024th accepted strobe (4096 bytes of 32-bit words). It stays high until the next start request.
- R8: While `done` is 1, `nextData` strobes cause no read, and `busOut` stays unchanged.
- R9: A full transfer performs exactly 1024 reads. No read address lies beyond base+1023.
- R10: A start request clears `done` in the following cycle. It also abandons any transfer in progress, and the next transfer begins again at the base word.
- R11: Between a start request and `attrValid`, `nextData` strobes cause no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle pulse that arms a new transfer |
| attrValid | input | 1 | Engine strobe marking the attribute cycle |
| attrIn | input | 32 | Transfer attributes to place on the bus |
| nextData | input | 1 | Engine strobe requesting the following word next cycle |
| ramRdData | input | 32 | Registered RAM read data (one-cycle latency) |
| ramEn | output | 1 | RAM read enable |
| ramAddr | output | 10 | RAM word address |
| busOut | output | 32 | Shared attribute/data bus to the engine |
| done | output | 1 | Whole block handed over |

## Verification
The assertions assume the following about the engine:
- `startReq` never coincides with `attrValid` or `nextData`.
- `attrValid` appears once per transfer, before any data strobe.
- The RAM port behaves as a register loaded only when `ramEn` is high.

The bench engine model respects these rules. It pulses start alone, gives one attribute cycle, then issues strobes in random bursts and gaps. Stray strobes are sent deliberately only before the attribute cycle and after completion, where the block must ignore them.

// File: rtl/dma_prefetch_pkg.sv
package dma_prefetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FLOW  = 2'd2,
    ST_DONE  = 2'd3
  } srcState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadBase;  // return pointer to block base
    logic fetch;     // issue a RAM read at the current pointer
    logic advance;   // step pointer after this read
  } srcStrobes_t;

endpackage

// File: rtl/dma_prefetch_ctrl.sv
module dma_prefetch_ctrl
  import dma_prefetch_pkg::*;
#(
  parameter int WORDS = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        attrValid,
  input  logic        nextData,
  output srcStrobes_t strobes,
  output logic        done
);

  localparam int CNT_W = $clog2(WORDS) + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_FETCH_IDX = CNT_W'(WORDS - 2);

  srcState_t state, stateNext;
  logic [CNT_W-1:0] handed, handedNext;

  always_comb begin
    strobes    = '0;
    stateNext  = state;
    handedNext = handed;
    if (startReq) begin
      strobes.loadBase = 1'b1;
      stateNext        = ST_ARMED;
      handedNext       = '0;
    end else begin
      unique case (state)
        ST_ARMED: if (attrValid) begin
          strobes.fetch   = 1'b1;  // prefetch first word in attribute cycle
          strobes.advance = 1'b1;
          stateNext       = ST_FLOW;
        end
        ST_FLOW: if (nextData) begin
          handedNext = handed + 1'b1;
          if (handed < LAST_IDX) begin
            strobes.fetch   = 1'b1;
            strobes.advance = (handed < LAST_FETCH_IDX);
          end else begin
            stateNext = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      handed <= '0;
    end else begin
      state  <= stateNext;
      handed <= handedNext;
    end
  end

  assign done = (state == ST_DONE);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done && !startReq |=> done) else $error("done dropped"); // R7

  AST_HANDED_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    handed <= CNT_W'(WORDS)) else $error("handed overflow"); // R9

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !startReq && !nextData |=> $stable(handed)) else $error("count moved"); // R4

endmodule

// File: rtl/dma_prefetch_dp.sv
module dma_prefetch_dp
  import dma_prefetch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  srcStrobes_t       strobes,
  input  logic              attrValid,
  input  logic [DATA_W-1:0] attrIn,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              ramEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] busOut
);

  logic [ADDR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= BASE_ADDR;
    end else if (strobes.loadBase) begin
      rdPtr <= BASE_ADDR;
    end else if (strobes.fetch && strobes.advance) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  assign ramEn   = strobes.fetch;
  assign ramAddr = rdPtr;
  // Shared bus: attributes in the attribute cycle, else the RAM register
  assign busOut  = attrValid ? attrIn : ramRdData;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadBase && !strobes.advance |=> $stable(rdPtr)) else $error("pointer drift"); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadBase && strobes.fetch && strobes.advance |=> rdPtr == $past(rdPtr) + 1'b1)
    else $error("pointer step"); // R5

endmodule

// File: rtl/dma_prefetch_src.sv
module dma_prefetch_src
  import dma_prefetch_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 4096,
  parameter int BASE_ADDR   = 0
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  logic                                           startReq,
  input  logic                                           attrValid,
  input  logic [DATA_W-1:0]                              attrIn,
  input  logic                                           nextData,
  input  logic [DATA_W-1:0]                              ramRdData,
  output logic                                           ramEn,
  output logic [$clog2(BLOCK_BYTES/(DATA_W/8))-1:0]      ramAddr,
  output logic [DATA_W-1:0]                              busOut,
  output logic                                           done
);

  localparam int WORDS  = BLOCK_BYTES / (DATA_W / 8);
  localparam int ADDR_W = $clog2(WORDS);

  srcStrobes_t strobes;

  dma_prefetch_ctrl #(.WORDS(WORDS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .attrValid (attrValid),
    .nextData  (nextData),
    .strobes   (strobes),
    .done      (done)
  );

  dma_prefetch_dp #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (ADDR_W'(BASE_ADDR))
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .attrValid (attrValid),
    .attrIn    (attrIn),
    .ramRdData (ramRdData),
    .ramEn     (ramEn),
    .ramAddr   (ramAddr),
    .busOut    (busOut)
  );

  AST_READ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ramEn |-> (attrValid || nextData)) else $error("unrequested read"); // R6

  AST_NO_READ_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ramEn) else $error("read after done"); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !done) else $error("done after start"); // R10

endmodule

// File: tb/tb_dma_prefetch_src.sv
module tb_dma_prefetch_src;

  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, attrValid = 1'b0, nextData = 1'b0;
  logic [31:0] attrIn = '0;
  logic [31:0] ramQ;
  logic        ramEn;
  logic [9:0]  ramAddr;
  logic [31:0] busOut;
  logic        done;

  int tests = 0, fails = 0;
  int phase = 0;        // 0 idle, 1 armed, 2 streaming, 3 after done
  int expRd = 0, rdCount = 0;
  logic [31:0] holdBus;
  logic [31:0] expQ[$];

  always #5 clk = ~clk;

  dma_prefetch_src dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .attrValid(attrValid),
    .attrIn(attrIn), .nextData(nextData), .ramRdData(ramQ),
    .ramEn(ramEn), .ramAddr(ramAddr), .busOut(busOut), .done(done)
  );

  function automatic logic [31:0] wordAt(int a);
    return 32'hC0DE0000 ^ (a * 32'h00010101) ^ 32'(a);
  endfunction

  // RAM model with one-cycle read latency
  always @(posedge clk) begin
    if (!rstN) ramQ <= '0;
    else if (ramEn) ramQ <= wordAt(int'(ramAddr));
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (startReq) begin
        expRd = 0;
        rdCount = 0;
      end
      if (ramEn) begin
        chk(attrValid || nextData, "R6 read without strobe", 32'(ramEn), 32'h0);
        chk(int'(ramAddr) == expRd, "R5 read address", 32'(ramAddr), 32'(expRd));
        chk(ramAddr <= 10'd1023, "R9 address bound", 32'(ramAddr), 32'd1023);
        expRd++;
        rdCount++;
      end
      if (attrValid) begin
        chk(busOut == attrIn, "R2 attribute on bus", busOut, attrIn);
        if (phase == 1)
          chk(ramEn && ramAddr == 10'd0, "R3 prefetch at attribute", {ramEn, 21'd0, ramAddr}, 32'h8000_0000);
      end
      if (nextData && phase == 1 && !attrValid)
        chk(!ramEn, "R11 early strobe ignored", 32'(ramEn), 32'h0);
      if (nextData && phase == 2) begin
        if (expQ.size() == 0) chk(1'b0, "R4 scoreboard empty", busOut, 32'h0);
        else begin
          logic [31:0] e;
          e = expQ.pop_front();
          chk(busOut == e, "R4 word order", busOut, e);
        end
        chk(!done, "R7 done early", 32'(done), 32'h0);
      end
      if (nextData && phase == 3) begin
        chk(!ramEn, "R8 no read after done", 32'(ramEn), 32'h0);
        chk(busOut == holdBus, "R8 bus held", busOut, holdBus);
        chk(done, "R8 done held", 32'(done), 32'h1);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic xfer(int words, logic [31:0] attr);
    logic wasDone;
    wasDone = done;
    expQ.delete();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    phase = 1;
    if (wasDone) chk(!done, "R10 start clears done", 32'(done), 32'h0);
    nextData = 1'b1;  // stray strobe before attributes
    tick();
    nextData = 1'b0;
    attrValid = 1'b1;
    attrIn = attr;
    tick();
    attrValid = 1'b0;
    for (int k = 0; k < WORDS; k++) expQ.push_back(wordAt(k));
    phase = 2;
    for (int k = 0; k < words; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        nextData = 1'b0;
        repeat ($urandom_range(1, 3)) tick();
      end
      nextData = 1'b1;
      tick();
    end
    nextData = 1'b0;
    phase = (words == WORDS) ? 3 : 0;
    holdBus = busOut;
  endtask

  initial begin
    repeat (3) tick();
    chk(!done && !ramEn, "R1 reset state", {31'd0, done} | {30'd0, ramEn, 1'b0}, 32'h0);
    rstN = 1'b1;
    tick();
    chk(!done && !ramEn, "R1 after reset release", {30'd0, ramEn, done}, 32'h0);

    xfer(WORDS, 32'hA77A_0001);
    @(negedge clk);
    chk(done, "R7 done after last word", 32'(done), 32'h1);
    chk(rdCount == WORDS, "R9 read count", 32'(rdCount), 32'(WORDS));
    tick();
    for (int i = 0; i < 3; i++) begin
      nextData = 1'b1;
      tick();
      nextData = 1'b0;
      tick();
    end
    chk(done, "R7 done sticky", 32'(done), 32'h1);

    xfer(300, 32'hA77A_0002);  // abandoned part way
    xfer(WORDS, 32'hA77A_0003);  // restart from base
    @(negedge clk);
    chk(done, "R10 restarted transfer completes", 32'(done), 32'h1);
    chk(rdCount == WORDS, "R9 read count after restart", 32'(rdCount), 32'(WORDS));
    tick();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule